// File: doc/BRIEF.md
# Tagged Resource Record Scanner

This block walks a 128-byte configuration image made of tagged items and pulls a 64-bit world-wide name out of it. Every item begins with a header byte. A short item carries its length and name in that byte. A long item carries a 7-bit name, and its 16-bit byte count sits in the two bytes that follow. One long item type holds a chain of sub-records. The scanner searches that chain for a keyword sub-record and copies the eight bytes that follow its header.

The scanner reads the image one byte at a time through a synchronous read port. It presents an address with a read enable, and the data comes back on the next cycle. A one-cycle `start` pulse begins a scan. While the scan runs, `busy` is high. When the scan ends, `done` rises and holds, and the name, its byte offset and a found flag are left on the outputs until the next start. Lengths that run off the end of the image are safe, because any byte at position 128 or above reads as zero and no port read is issued for it.

Top module: `tagged_record_scanner`

## Requirements
- R1: After reset, busy, done and found are 0, and wwn and wwn_offset are 0.
- R2: A header byte with bit 7 clear is a short item. Its length is bits 2:0 plus 1 and its name is bits 6:3. A short item named 0xF ends the scan at once. Scanning begins at offset 0 and stops when the next header offset is 128 or more.
- R3: A header byte with bit 7 set is a long item named by bits 6:0. It spans 3 bytes plus the little-endian 16-bit count in the next two bytes (low byte first). Long items with any name other than 0x0D are passed over without being searched.
- R4: In a 0x0D item, if the byte right after the 3-byte header is 0x3B, the item counts as 6 bytes long and its contents are not searched.
- R5: Inside a 0x0D item, sub-records start right after the item header. Each one has a name in bits 5:0 of its first byte and a little-endian 16-bit count in the next two bytes. The walk moves by that count plus 3 and stops once it reaches the item's end.
- R6: A sub-record named 0x3C sets found. The eight bytes after its 3-byte header go to wwn, with the first byte in bits 63:56. The position of that first byte goes to wwn_offset.
- R7: When more than one 0x3C sub-record is met, the last one met sets wwn and wwn_offset.
- R8: When no 0x3C sub-record is met, found is 0 and wwn and wwn_offset are both 0.
- R9: A byte at position 128 or above reads as zero, and mem_rd_en is never raised for it. This applies to header, count and captured name bytes alike.
- R10: done stays high and the results stay unchanged until the next start. A start while busy is ignored, and busy and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a scan while idle |
| mem_addr | output | 7 | Image byte address |
| mem_rd_en | output | 1 | Read strobe; data is expected on mem_rd_data one cycle later |
| mem_rd_data | input | 8 | Byte returned by the image memory |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished; results valid |
| found | output | 1 | A keyword sub-record was captured |
| wwn | output | 64 | Captured name, first byte in bits 63:56 |
| wwn_offset | output | 8 | Image offset of the first captured byte, 0 when none |

## Verification
Directed images each isolate one rule. An all-zero image walks 128 one-byte items and finds nothing. An end tag placed ahead of a valid record must hide that record. A keyword inside a long item with a different name must be ignored. A 0x3B marker must skip a record that a plain walk would capture. Two keywords in one item show which capture wins. A keyword at offset 126, placed behind nonzero bytes near address 0, shows whether bytes past the image read as zero or wrap around. A 0xFFFF count shows that a runaway length still ends the scan. Structured random images mix short items, foreign long items and searched items with random sub-records, and fully random bytes add malformed layouts. Both kinds are compared against a bench model of the walk.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_LLO,
    ST_LHI,
    ST_PEEK,
    ST_SCHK,
    ST_SUB,
    ST_SLO,
    ST_SHI,
    ST_CAP
  } scan_st_e;

  localparam logic [3:0] END_TAG_NAME  = 4'hF;
  localparam logic [6:0] SEARCH_NAME   = 7'h0D;
  localparam logic [7:0] SKIP_MARK     = 8'h3B;
  localparam int         SKIP_LEN      = 6;
  localparam logic [5:0] KEY_SUB_NAME  = 6'h3C;
  localparam int         LONG_HDR_LEN  = 3;

endpackage

// File: rtl/scan_fetch.sv
module scan_fetch #(
  parameter int IMG_BYTES = 128,
  parameter int POS_W     = 18,
  localparam int AW       = $clog2(IMG_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [POS_W-1:0] pos,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_rd_en,
  input  logic [7:0]       mem_rd_data,
  output logic             rsp_valid,
  output logic [7:0]       rsp_data
);

  logic in_range;
  logic live_q;

  assign in_range  = pos < POS_W'(IMG_BYTES);
  assign mem_addr  = pos[AW-1:0];
  assign mem_rd_en = req && in_range;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      live_q    <= 1'b0;
    end else begin
      rsp_valid <= req;
      live_q    <= req && in_range;
    end
  end

  assign rsp_data = live_q ? mem_rd_data : 8'h00;

endmodule

// File: rtl/scan_hdr_decode.sv
module scan_hdr_decode (
  input  logic [7:0] hdr,
  output logic       is_long,
  output logic [3:0] short_len,
  output logic [3:0] short_name,
  output logic [6:0] long_name,
  output logic [5:0] sub_name
);

  assign is_long    = hdr[7];
  assign short_len  = {1'b0, hdr[2:0]} + 4'd1;
  assign short_name = hdr[6:3];
  assign long_name  = hdr[6:0];
  assign sub_name   = hdr[5:0];

endmodule

// File: rtl/scan_name_shift.sv
module scan_name_shift #(
  parameter int NAME_BYTES = 8,
  localparam int W         = NAME_BYTES * 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic [7:0]   din,
  output logic [W-1:0] nxt
);

  logic [W-1:0] q;

  assign nxt = {q[W-9:0], din};

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= nxt;
  end

endmodule

// File: rtl/tagged_record_scanner.sv
module tagged_record_scanner
  import scan_pkg::*;
#(
  parameter int  IMG_BYTES  = 128,
  parameter int  NAME_BYTES = 8,
  localparam int AW         = $clog2(IMG_BYTES),
  localparam int OFS_W      = AW + 1,
  localparam int NAME_W     = NAME_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd_en,
  input  logic [7:0]        mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [NAME_W-1:0] wwn,
  output logic [OFS_W-1:0]  wwn_offset
);

  localparam int POS_W = ((AW > 16) ? AW : 16) + 2;
  localparam int CNT_W = (NAME_BYTES > 1) ? $clog2(NAME_BYTES) : 1;

  scan_st_e          st;
  logic              pend;
  logic [POS_W-1:0]  i_pos, j_pos, item_end, sub_step;
  logic [7:0]        lo_byte;
  logic [6:0]        lname;
  logic [5:0]        sname;
  logic [CNT_W-1:0]  cap_cnt;

  logic [POS_W-1:0]  rd_pos;
  logic              rd_state, hdr_exhausted, req;
  logic              rsp_valid;
  logic [7:0]        rsp_data;
  logic              is_long;
  logic [3:0]        short_len, short_name;
  logic [6:0]        long_name;
  logic [5:0]        sub_name;
  logic [POS_W-1:0]  wide_len;
  logic              got;
  logic [NAME_W-1:0] name_nxt;

  always_comb begin
    case (st)
      ST_HDR:  rd_pos = i_pos;
      ST_LLO:  rd_pos = i_pos + POS_W'(1);
      ST_LHI:  rd_pos = i_pos + POS_W'(2);
      ST_SLO:  rd_pos = j_pos + POS_W'(1);
      ST_SHI:  rd_pos = j_pos + POS_W'(2);
      ST_CAP:  rd_pos = j_pos + POS_W'(LONG_HDR_LEN) + POS_W'(cap_cnt);
      default: rd_pos = j_pos;
    endcase
  end

  assign rd_state      = (st != ST_IDLE) && (st != ST_SCHK);
  assign hdr_exhausted = (st == ST_HDR) && (i_pos >= POS_W'(IMG_BYTES));
  assign req           = rd_state && !pend && !hdr_exhausted;
  assign got           = pend && rsp_valid;
  assign wide_len      = POS_W'({rsp_data, lo_byte}) + POS_W'(LONG_HDR_LEN);

  scan_fetch #(.IMG_BYTES(IMG_BYTES), .POS_W(POS_W)) u_fetch (
    .clk(clk), .rst(rst), .req(req), .pos(rd_pos),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  scan_hdr_decode u_dec (
    .hdr(rsp_data), .is_long(is_long), .short_len(short_len),
    .short_name(short_name), .long_name(long_name), .sub_name(sub_name)
  );

  scan_name_shift #(.NAME_BYTES(NAME_BYTES)) u_shift (
    .clk(clk), .rst(rst), .shift_en(got && (st == ST_CAP)),
    .din(rsp_data), .nxt(name_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      pend       <= 1'b0;
      i_pos      <= '0;
      j_pos      <= '0;
      item_end   <= '0;
      sub_step   <= '0;
      lo_byte    <= '0;
      lname      <= '0;
      sname      <= '0;
      cap_cnt    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      found      <= 1'b0;
      wwn        <= '0;
      wwn_offset <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            i_pos      <= '0;
            pend       <= 1'b0;
            busy       <= 1'b1;
            done       <= 1'b0;
            found      <= 1'b0;
            wwn        <= '0;
            wwn_offset <= '0;
            st         <= ST_HDR;
          end
        end
        ST_SCHK: begin
          // Past the image every sub-record reads as zero and cannot match,
          // so the rest of the item is skipped in one step.
          if (j_pos >= item_end || j_pos >= POS_W'(IMG_BYTES)) begin
            i_pos <= item_end;
            st    <= ST_HDR;
          end else begin
            st <= ST_SUB;
          end
        end
        default: begin
          if (!pend) begin
            if (hdr_exhausted) begin
              st   <= ST_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              pend <= 1'b1;
            end
          end else if (rsp_valid) begin
            pend <= 1'b0;
            case (st)
              ST_HDR: begin
                if (!is_long) begin
                  if (short_name == END_TAG_NAME) begin
                    st   <= ST_IDLE;
                    busy <= 1'b0;
                    done <= 1'b1;
                  end else begin
                    i_pos <= i_pos + POS_W'(short_len);
                  end
                end else begin
                  lname <= long_name;
                  st    <= ST_LLO;
                end
              end
              ST_LLO: begin
                lo_byte <= rsp_data;
                st      <= ST_LHI;
              end
              ST_LHI: begin
                if (lname == SEARCH_NAME) begin
                  j_pos    <= i_pos + POS_W'(LONG_HDR_LEN);
                  item_end <= i_pos + wide_len;
                  st       <= ST_PEEK;
                end else begin
                  i_pos <= i_pos + wide_len;
                  st    <= ST_HDR;
                end
              end
              ST_PEEK: begin
                if (rsp_data == SKIP_MARK) begin
                  i_pos <= i_pos + POS_W'(SKIP_LEN);
                  st    <= ST_HDR;
                end else begin
                  st <= ST_SCHK;
                end
              end
              ST_SUB: begin
                sname <= sub_name;
                st    <= ST_SLO;
              end
              ST_SLO: begin
                lo_byte <= rsp_data;
                st      <= ST_SHI;
              end
              ST_SHI: begin
                if (sname == KEY_SUB_NAME) begin
                  sub_step <= wide_len;
                  cap_cnt  <= '0;
                  st       <= ST_CAP;
                end else begin
                  j_pos <= j_pos + wide_len;
                  st    <= ST_SCHK;
                end
              end
              ST_CAP: begin
                if (cap_cnt == CNT_W'(NAME_BYTES - 1)) begin
                  found      <= 1'b1;
                  wwn        <= name_nxt;
                  wwn_offset <= OFS_W'(j_pos + POS_W'(LONG_HDR_LEN));
                  j_pos      <= j_pos + sub_step;
                  st         <= ST_SCHK;
                end else begin
                  cap_cnt <= cap_cnt + CNT_W'(1);
                end
              end
              default: st <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // R8: without a capture the name and offset stay cleared
  assert_clear_without_match_R8: assert property (@(posedge clk) disable iff (rst)
    !found |-> (wwn_offset == '0 && wwn == '0));

  // R6: a captured name lies after a long header and a sub-record header
  assert_offset_past_headers_R6: assert property (@(posedge clk) disable iff (rst)
    found |-> (wwn_offset >= OFS_W'(2 * LONG_HDR_LEN)));

  assert_done_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  assert_busy_done_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  assert_response_expected_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> pend);

  assert_read_only_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy);

endmodule

// File: tb/tagged_record_scanner_bench.sv
module tagged_record_scanner_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [6:0]  mem_addr;
  logic        mem_rd_en;
  logic [7:0]  mem_rd_data = 8'h00;
  logic        busy, done, found;
  logic [63:0] wwn;
  logic [7:0]  wwn_offset;

  logic [7:0]  img [128];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  tagged_record_scanner u_tagged_record_scanner (
    .clk(clk), .rst(rst), .start(start),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
    .busy(busy), .done(done), .found(found), .wwn(wwn), .wwn_offset(wwn_offset)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= img[mem_addr];
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog R10: actual running, expected finished");
      finish_run();
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int rb(int p);
    return (p < 128) ? int'(img[p]) : 0;
  endfunction

  task automatic ref_scan(output bit f, output logic [63:0] w, output int o);
    int i = 0;
    bit fin = 0;
    f = 0; w = '0; o = 0;
    while (i < 128 && !fin) begin
      int z = rb(i);
      int len;
      if ((z & 128) == 0) begin
        len = 1 + (z & 7);
        if (((z >> 3) & 15) == 15) fin = 1;
      end else begin
        len = 3 + rb(i + 1) + (rb(i + 2) << 8);
        if ((z & 127) == 13) begin
          int j = i + 3;
          if (rb(j) == 59) len = 6;
          else begin
            while (j < i + len) begin
              int sn = rb(j) & 63;
              int sl = rb(j + 1) + (rb(j + 2) << 8);
              if (sn == 60) begin
                w = '0;
                for (int k = 0; k < 8; k++) w = {w[55:0], 8'(rb(j + 3 + k))};
                o = j + 3;
                f = 1;
              end
              j = j + sl + 3;
            end
          end
        end
      end
      i = i + len;
    end
  endtask

  task automatic clear_img();
    for (int k = 0; k < 128; k++) img[k] = 8'h00;
  endtask

  task automatic put(int p, int v);
    if (p >= 0 && p < 128) img[p] = 8'(v);
  endtask

  task automatic run_scan(bit poke_busy);
    int wait_n = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke_busy) begin
      @(negedge clk);
      check("R10 busy during scan", 64'(busy), 64'd1);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done && wait_n < 8000) begin
      @(negedge clk);
      wait_n++;
    end
    if (!done) check("R10 scan completes", 64'(done), 64'd1);
  endtask

  task automatic scan_and_compare(string req);
    bit ef; logic [63:0] ew; int eo;
    ref_scan(ef, ew, eo);
    run_scan(1'b0);
    check(req, 64'(found), 64'(ef));
    check(req, wwn, ew);
    check(req, 64'(wwn_offset), 64'(eo));
  endtask

  task automatic build_random();
    int p = 0;
    clear_img();
    while (p < 110) begin
      int kind = $urandom % 4;
      if (kind == 0) begin
        int k = 1 + ($urandom % 8);
        put(p, (($urandom % 15) << 3) | (k - 1));
        for (int b = 1; b < k; b++) put(p + b, $urandom);
        p += k;
      end else if (kind == 1) begin
        int nm = $urandom % 128;
        int l = $urandom % 7;
        if (nm == 13) nm = 14;
        put(p, 128 | nm); put(p + 1, l); put(p + 2, 0);
        for (int b = 0; b < l; b++) put(p + 3 + b, $urandom);
        p += 3 + l;
      end else begin
        int q = p + 3;
        int nsub = 1 + ($urandom % 3);
        if ($urandom % 8 == 0) begin
          put(q, 8'h3B);
          q += 3;
        end else begin
          for (int s = 0; s < nsub; s++) begin
            int sl;
            if ($urandom % 3 == 0) begin
              put(q, ($urandom & 8'hC0) | 8'h3C);
              sl = 8 + ($urandom % 3);
            end else begin
              put(q, $urandom);
              sl = $urandom % 5;
            end
            put(q + 1, sl); put(q + 2, 0);
            for (int b = 0; b < sl; b++) put(q + 3 + b, $urandom);
            q += 3 + sl;
          end
        end
        put(p, 8'h8D); put(p + 1, q - p - 3); put(p + 2, 0);
        p = q;
      end
    end
    if ($urandom % 2 == 0) put(p, 8'h78);
  endtask

  initial begin
    void'($urandom(32'd7331));
    clear_img();
    repeat (3) @(negedge clk);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check("R1 found", 64'(found), 64'd0);
    check("R1 wwn", wwn, 64'd0);
    check("R1 offset", 64'(wwn_offset), 64'd0);
    rst = 1'b0;

    // R8 / R2: all-zero image, 128 one-byte short items, nothing found
    clear_img();
    run_scan(1'b1);
    check("R8 found", 64'(found), 64'd0);
    check("R8 offset", 64'(wwn_offset), 64'd0);
    check("R8 wwn", wwn, 64'd0);

    // R6 / R5 / R3: short item, searched item with a filler sub-record then the key
    clear_img();
    put(0, 8'h02);
    put(3, 8'h8D); put(4, 15); put(5, 0);
    put(6, 8'h01); put(7, 1); put(8, 0); put(9, 8'hEE);
    put(10, 8'h3C); put(11, 8); put(12, 0);
    for (int b = 0; b < 8; b++) put(13 + b, 8'h10 + b);
    put(21, 8'h78);
    run_scan(1'b0);
    check("R6 found", 64'(found), 64'd1);
    check("R6 wwn byte order", wwn, 64'h1011121314151617);
    check("R6 offset", 64'(wwn_offset), 64'd13);
    repeat (3) @(negedge clk);
    check("R10 done holds", 64'(done), 64'd1);
    check("R10 result holds", wwn, 64'h1011121314151617);

    // R2: end tag ahead of a valid record
    clear_img();
    put(0, 8'h78);
    put(1, 8'h8D); put(2, 11); put(3, 0);
    put(4, 8'h3C); put(5, 8); put(6, 0);
    for (int b = 0; b < 8; b++) put(7 + b, 8'hA0 + b);
    run_scan(1'b0);
    check("R2 end tag stops scan", 64'(found), 64'd0);

    // R3: key bytes inside a long item with another name
    clear_img();
    put(0, 8'h8E); put(1, 11); put(2, 0);
    put(3, 8'h3C); put(4, 8); put(5, 0);
    for (int b = 0; b < 8; b++) put(6 + b, 8'h55);
    put(14, 8'h78);
    run_scan(1'b0);
    check("R3 foreign long item not searched", 64'(found), 64'd0);

    // R4: 0x3B marker hides a key that a plain walk would reach
    clear_img();
    put(0, 8'h8D); put(1, 20); put(2, 0);
    put(3, 8'h3B); put(6, 8'h3C);
    for (int b = 9; b < 17; b++) put(b, 8'h99);
    put(11, 8'h78);
    run_scan(1'b0);
    check("R4 skip marker", 64'(found), 64'd0);
    check("R4 skip marker offset", 64'(wwn_offset), 64'd0);

    // R7: two keys in one item, the later one wins
    clear_img();
    put(0, 8'h8D); put(1, 22); put(2, 0);
    put(3, 8'h3C); put(4, 8); put(5, 0);
    for (int b = 0; b < 8; b++) put(6 + b, 8'h20 + b);
    put(14, 8'hFC); put(15, 8); put(16, 0);
    for (int b = 0; b < 8; b++) put(17 + b, 8'h40 + b);
    put(25, 8'h78);
    run_scan(1'b0);
    check("R7 later key wins", wwn, 64'h4041424344454647);
    check("R7 later key offset", 64'(wwn_offset), 64'd17);

    // R9: key at 126, captured bytes past the image; nonzero bytes near 0 catch wrapping
    clear_img();
    put(0, 8'h07);
    for (int b = 1; b < 8; b++) put(b, 8'h11 * b);
    put(8, 8'h07);
    for (int b = 9; b < 16; b++) put(b, 8'h5A);
    put(123, 8'h8D); put(124, 8'h40); put(125, 0);
    put(126, 8'h3C); put(127, 8'h08);
    run_scan(1'b0);
    check("R9 found at edge", 64'(found), 64'd1);
    check("R9 bytes past image are zero", wwn, 64'd0);
    check("R9 offset past image", 64'(wwn_offset), 64'd129);

    // R9 / R5: runaway item count still ends the scan
    clear_img();
    put(0, 8'h8D); put(1, 8'hFF); put(2, 8'hFF);
    put(3, 8'h05); put(4, 1); put(5, 0);
    scan_and_compare("R9 runaway length");

    for (int n = 0; n < 40; n++) begin
      build_random();
      scan_and_compare("R5 structured random");
    end
    for (int n = 0; n < 12; n++) begin
      for (int k = 0; k < 128; k++) img[k] = 8'($urandom);
      scan_and_compare("R3 raw random");
    end

    finish_run();
  end

endmodule